// File: doc/BRIEF.md
# Colour Lookup Table Loader

This block holds a 256-entry RGB colour lookup table and loads it through a small 32-bit register window. Software first writes an entry number to the index register. It then writes the data register three times, once for each colour component. The components go in a fixed order: red, then green, then blue. When the blue component has been stored, the block steps the index to the next entry by itself. Software can therefore load a whole table, or any run of consecutive entries, with one index write followed by a stream of data writes.

The display datapath reads the table through its own synchronous read port. It presents an entry number and gets back the 24-bit colour one clock later. The three component arrays are plain RAMs with no reset, so that block RAM can be used for them. After reset, a sweep engine writes the power-on contents into the arrays: every entry is black except the last one, which is white. While that sweep runs, the block ignores bus writes.

Top module: `clut_loader`

## Requirements
- R1: A write to byte offset 0 (the index register) loads the entry index from write-data bits 31:24. It also returns the component sequencer to red, so the next data write goes to red.
- R2: Each write to byte offset 4 (the data register) stores write-data bits 31:24 as one component of the entry at the current index. The components are taken in turn: red, green, blue. The other components of that entry and all other entries keep their values.
- R3: A data write that stores blue advances the index by one, wrapping from 255 to 0. The sequencer then returns to red, so the next entry is loaded with no further index write.
- R4: After reset, every entry reads as zero except entry 255, which reads as 0xFFFFFF. After reset the index is 0 and the sequencer is at red.
- R5: Bus writes to byte offsets 8 and 12 are ignored. Bus writes to any address whose two low bits are not zero are also ignored. Ignored means that no table entry, the index and the component state all keep their values.
- R6: The bus read data is zero at all times.
- R7: The value on `lut_rdata` is the colour of the entry named on `lut_raddr` at the previous rising edge. Red is in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R8: For the 256 cycles that follow the release of reset, the initialisation sweep writes the arrays. During this time, bus writes have no effect on the table, the index or the sequencer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for a 32-bit access |
| bus_addr | input | 4 | Byte address within the 16-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| lut_raddr | input | 8 | Display-side entry number |
| lut_rdata | output | 24 | Display-side colour, one cycle after the address |

## Verification
Several properties are checked on every cycle:
- the sequencer stays one-hot and moves through the three phases in order;
- an index write sets the index and phase as specified;
- a blue write steps the index by exactly one, with wrap-around;
- the index and phase hold still on any cycle without an accepted write;
- no bus write reaches the arrays while the sweep is running;
- the sweep ends after its final entry.

The table contents can only be shown by the bench's scenarios. These include the power-on image and full 768-write loads with computed patterns, including the wrap past entry 255. They also include a reload of the index in the middle of an entry, writes to unused or misaligned addresses, writes issued during the sweep, and the one-cycle read latency.

// File: rtl/clut_pkg.sv
package clut_pkg;
  // Component phase of the data-register sequencer, one-hot.
  typedef enum logic [2:0] {
    CMP_RED = 3'b001,
    CMP_GRN = 3'b010,
    CMP_BLU = 3'b100
  } comp_e;

  localparam int NCOMP = 3;
endpackage

// File: rtl/clut_regs.sv
module clut_regs
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [NCOMP-1:0]  cmp_we,
  output logic [COMP_W-1:0] cmp_data
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] WORD_IDX = WORD_W'(0);
  localparam logic [WORD_W-1:0] WORD_DAT = WORD_W'(1);

  comp_e             comp_q;
  logic [IDX_W-1:0]  idx_q;
  logic              aligned;
  logic [WORD_W-1:0] word;
  logic              hit_idx;
  logic              hit_dat;

  assign aligned = (addr[1:0] == 2'b00);
  assign word    = addr[ADDR_W-1:2];
  assign hit_idx = wr_en && accept && aligned && (word == WORD_IDX);
  assign hit_dat = wr_en && accept && aligned && (word == WORD_DAT);

  assign cmp_we   = hit_dat ? comp_q : '0;
  assign cmp_data = wdata[BUS_W-1 -: COMP_W];
  assign cur_idx  = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      comp_q <= CMP_RED;
    end else if (hit_idx) begin
      idx_q  <= wdata[BUS_W-1 -: IDX_W];
      comp_q <= CMP_RED;
    end else if (hit_dat) begin
      case (comp_q)
        CMP_RED: comp_q <= CMP_GRN;
        CMP_GRN: comp_q <= CMP_BLU;
        default: begin
          comp_q <= CMP_RED;
          idx_q  <= idx_q + 1'b1;
        end
      endcase
    end
  end

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot(comp_q)); // R2
  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (rst)
    hit_idx |=> (idx_q == $past(wdata[BUS_W-1 -: IDX_W])) && (comp_q == CMP_RED)); // R1
  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst)
    (hit_dat && comp_q == CMP_RED) |=> (comp_q == CMP_GRN) && $stable(idx_q)); // R2
  AST_BLUE_STEP: assert property (@(posedge clk) disable iff (rst)
    (hit_dat && comp_q == CMP_BLU) |=> (idx_q == $past(idx_q) + 1'b1) && (comp_q == CMP_RED)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(hit_idx || hit_dat) |=> $stable(idx_q) && $stable(comp_q)); // R5
endmodule

// File: rtl/clut_init.sv
module clut_init #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic             busy,
  output logic [IDX_W-1:0] waddr,
  output logic             white
);
  localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

  logic [IDX_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end

  assign busy  = busy_q;
  assign waddr = cnt_q;
  assign white = (cnt_q == LAST);

  AST_SWEEP_END: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q == LAST) |=> !busy_q); // R8
  AST_SWEEP_STAYS_DONE: assert property (@(posedge clk) disable iff (rst)
    !busy_q |=> !busy_q); // R8
endmodule

// File: rtl/clut_ram.sv
module clut_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/clut_loader.sv
module clut_loader
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [BUS_W-1:0]        bus_wdata,
  output logic [BUS_W-1:0]        bus_rdata,
  input  logic [IDX_W-1:0]        lut_raddr,
  output logic [NCOMP*COMP_W-1:0] lut_rdata
);
  logic              sweep_busy;
  logic [IDX_W-1:0]  sweep_addr;
  logic              sweep_white;
  logic [IDX_W-1:0]  cur_idx;
  logic [NCOMP-1:0]  cmp_we;
  logic [COMP_W-1:0] cmp_data;

  assign bus_rdata = '0;

  clut_init #(.IDX_W(IDX_W)) u_init (
    .clk   (clk),
    .rst   (rst),
    .busy  (sweep_busy),
    .waddr (sweep_addr),
    .white (sweep_white)
  );

  clut_regs #(
    .IDX_W(IDX_W), .COMP_W(COMP_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .accept   (!sweep_busy),
    .wr_en    (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .cur_idx  (cur_idx),
    .cmp_we   (cmp_we),
    .cmp_data (cmp_data)
  );

  // One array per component; bit c of cmp_we selects red(0), green(1), blue(2).
  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    logic              we_c;
    logic [IDX_W-1:0]  wa_c;
    logic [COMP_W-1:0] wd_c;
    logic [COMP_W-1:0] rd_c;

    assign we_c = sweep_busy | cmp_we[c];
    assign wa_c = sweep_busy ? sweep_addr : cur_idx;
    assign wd_c = sweep_busy ? {COMP_W{sweep_white}} : cmp_data;

    clut_ram #(.AW(IDX_W), .DW(COMP_W)) u_ram (
      .clk   (clk),
      .we    (we_c),
      .waddr (wa_c),
      .wdata (wd_c),
      .raddr (lut_raddr),
      .rdata (rd_c)
    );

    assign lut_rdata[(NCOMP-1-c)*COMP_W +: COMP_W] = rd_c;
  end

  AST_SWEEP_BLOCKS_BUS: assert property (@(posedge clk) disable iff (rst)
    sweep_busy |-> (cmp_we == '0)); // R8
  AST_ONE_COMPONENT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmp_we)); // R2
endmodule

// File: tb/sim_clut_loader.sv
`timescale 1ns/1ps
module sim_clut_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  lut_raddr = '0;
  logic [23:0] lut_rdata;

  int total = 0;
  int bad = 0;

  logic [7:0] mr [256];
  logic [7:0] mg [256];
  logic [7:0] mb [256];
  logic [7:0] midx;
  int         mcomp;

  always #2.5 clk = ~clk;

  clut_loader u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lut_raddr(lut_raddr), .lut_rdata(lut_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic raw_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_index(input logic [7:0] v);
    raw_wr(4'h0, {v, 24'h000000});
    midx = v; mcomp = 0;
  endtask

  task automatic wr_data(input logic [7:0] v);
    raw_wr(4'h4, {v, 24'h00a5c3});
    case (mcomp)
      0: mr[midx] = v;
      1: mg[midx] = v;
      default: begin mb[midx] = v; midx = midx + 8'd1; end
    endcase
    mcomp = (mcomp + 1) % 3;
  endtask

  task automatic rd_entry(input logic [7:0] a, output logic [23:0] v);
    @(negedge clk);
    lut_raddr = a;
    @(negedge clk);
    v = lut_rdata;
  endtask

  task automatic verify_all(input string req);
    logic [23:0] v;
    for (int i = 0; i < 256; i++) begin
      rd_entry(8'(i), v);
      chk(req, {8'h00, v}, {8'h00, mr[i], mg[i], mb[i]});
    end
  endtask

  task automatic verify_one(input string req, input logic [7:0] a);
    logic [23:0] v;
    rd_entry(a, v);
    chk(req, {8'h00, v}, {8'h00, mr[a], mg[a], mb[a]});
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] v;
    for (int i = 0; i < 256; i++) begin
      mr[i] = (i == 255) ? 8'hff : 8'h00;
      mg[i] = mr[i]; mb[i] = mr[i];
    end
    midx = 8'd0; mcomp = 0;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R6 rdata after reset", bus_rdata, 32'h0);
    // R8: writes during the sweep must be ignored (model not updated)
    raw_wr(4'h0, 32'h07000000);
    raw_wr(4'h4, 32'haa000000);
    raw_wr(4'h4, 32'hbb000000);
    repeat (280) @(negedge clk);
    verify_all("R4 power-on image");

    // R4/R8: index 0 and red phase after reset, sweep-time writes left no trace
    wr_data(8'h11); wr_data(8'h22); wr_data(8'h33);
    verify_one("R4 first entry after reset", 8'h00);
    verify_one("R8 entry 7 untouched", 8'h07);
    chk("R6 rdata after writes", bus_rdata, 32'h0);

    // R3: wrap past 255
    wr_index(8'hfe);
    for (int k = 0; k < 9; k++) wr_data(8'(8'h40 + k));
    verify_one("R3 entry fe", 8'hfe);
    verify_one("R3 entry ff", 8'hff);
    verify_one("R3 wrapped entry 0", 8'h00);
    wr_data(8'h77);
    verify_one("R3 entry 1 red after wrap", 8'h01);

    // R2/R3: full table load with computed pattern
    wr_index(8'h00);
    for (int i = 0; i < 256; i++) begin
      wr_data(8'(i));
      wr_data(8'(i) ^ 8'h5a);
      wr_data(~8'(i));
    end
    verify_all("R2 full load");

    // R1: index reload mid-entry restarts at red
    wr_index(8'd10);
    wr_data(8'hc1);
    wr_index(8'd20);
    wr_data(8'hd1); wr_data(8'hd2); wr_data(8'hd3);
    verify_one("R1 entry 10 partial", 8'd10);
    verify_one("R1 entry 20 full", 8'd20);
    verify_one("R1 entry 21 untouched", 8'd21);

    // R5: unused and misaligned offsets ignored
    wr_index(8'd40);
    wr_data(8'he1);
    raw_wr(4'h8, 32'h55000000);
    raw_wr(4'hc, 32'h66000000);
    raw_wr(4'h1, 32'h77000000);
    raw_wr(4'h5, 32'h88000000);
    raw_wr(4'h6, 32'h99000000);
    raw_wr(4'h3, 32'hab000000);
    wr_data(8'he2); wr_data(8'he3);
    verify_one("R5 entry 40", 8'd40);
    verify_one("R5 entry 41", 8'd41);
    chk("R6 rdata after ignored writes", bus_rdata, 32'h0);

    // R7: one-cycle latency, red in the top byte
    @(negedge clk);
    lut_raddr = 8'd20;
    @(negedge clk);
    lut_raddr = 8'd40;
    chk("R7 latency first", {8'h00, lut_rdata}, 32'h00d1d2d3);
    @(negedge clk);
    chk("R7 latency second", {8'h00, lut_rdata}, {8'h00, mr[40], mg[40], mb[40]});
    rd_entry(8'd5, v);
    chk("R7 pattern entry 5", {8'h00, v}, {8'h00, 8'h05, 8'h05 ^ 8'h5a, ~8'h05});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule